// File: doc/BRIEF.md
# Data Object Mailbox Responder

This block is the device side of a dword mailbox used to exchange data objects. A host writes request dwords one at a time into a write port. It then issues a start command. The block checks the object's length header before it dispatches the request. A valid request is streamed out of a responder port, one dword per handshake. The responder streams its answer back into a response buffer. When the whole answer is in that buffer, the host pulls it out through a read port. The read port shows the current dword, and a separate acknowledge write moves it to the next one.

Every object starts with two header dwords. The first holds a 16-bit vendor identifier and an 8-bit type; the block passes it through without interpreting it. The second holds, in bits 17:0, the object's total size in dwords, counting both header dwords. A field value of zero stands for 2^18 dwords. Three status flags report the mailbox state: busy, error and response ready. An abort command clears all three and discards any partial request or response. Both buffers are `DEPTH` dwords deep.

Top module: `objx_mailbox`

## Requirements
- R1: After reset, `st_busy`, `st_error`, `st_ready`, `req_vld` and `rsp_rdy` are 0 and `host_rdata` is 0.
- R2: Host register select codes: 0 = control, 1 = write mailbox, 2 = read mailbox. In a control write, bit 0 is abort and bit 31 is start. The length of the staged request is taken from bits 17:0 of the second stored dword, and 0 decodes to 262144.
- R3: A start issued in the idle state, with error and ready both clear, is accepted when the decoded length L satisfies 2 ≤ L ≤ stored count. From the next cycle `st_busy` is 1 and `req_vld` presents the first L stored dwords in order, with `req_last` on the L-th. Each dword advances on `req_rdy`, and the dword is held stable while `req_rdy` is low.
- R4: A start that meets the R3 conditions except the length check sets `st_error` in the next cycle. The length check fails when fewer than 2 dwords are stored, when L < 2, or when L exceeds the stored count (this includes L = 0 decoded as 262144 and any L above `DEPTH`). In that case `st_busy` and `req_vld` stay 0.
- R5: A write-mailbox write while `st_busy` is 1 is not stored and sets `st_error`. The request stream in progress is unchanged.
- R6: A write-mailbox write while `DEPTH` dwords are already stored is dropped and sets `st_error`.
- R7: After dispatch, the block holds `rsp_rdy` at 1 and stores every `rsp_vld` beat. In the cycle after the beat with `rsp_last`, `st_busy` falls and `st_ready` rises. Beats that arrive when `DEPTH` dwords are already held are dropped and set `st_error`. `st_busy` and `st_ready` are never 1 together.
- R8: While `st_ready` is 1, `host_rdata` shows the current response dword. Reading it, or waiting, does not consume it. Any write to the read mailbox advances to the next dword. `st_ready` stays 1 until the acknowledge of the final dword, and after that it is 0 and `host_rdata` is 0.
- R9: A control write with bit 0 set clears `st_busy`, `st_error`, `st_ready`, `req_vld` and `rsp_rdy` in the next cycle and empties both buffers. Abort takes priority when the start bit is set in the same write.
- R10: A start issued while busy, while error is set, or while a response is ready has no effect: no dispatch and no change to busy or ready.
- R11: A read-mailbox write while `st_ready` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 control, 1 write mailbox, 2 read mailbox |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current response dword (0 when not ready) |
| st_busy | output | 1 | Request dispatched, response not yet complete |
| st_error | output | 1 | Sticky error flag, cleared by abort |
| st_ready | output | 1 | Response object available to read |
| req_vld | output | 1 | Request dword valid toward responder |
| req_dw | output | 32 | Request dword |
| req_last | output | 1 | Final dword of the request object |
| req_rdy | input | 1 | Responder accepts the request dword |
| rsp_vld | input | 1 | Response dword valid from responder |
| rsp_dw | input | 32 | Response dword |
| rsp_last | input | 1 | Final dword of the response object |
| rsp_rdy | output | 1 | Block accepts response dwords |

## Verification
The hardest states to reach are the ones where host commands meet a transfer that is still in flight. Examples are a write-mailbox write or an abort arriving while a request dword is stalled on the responder port, and an abort arriving halfway through a response. The bench can hold the responder's ready low on demand, which pins a transfer at a known dword. It also feeds response beats one by one without an end marker, which parks the block mid-collection. The host command is then issued into that frozen state. A response longer than the buffer exercises the drop-and-flag path, and after that every kept dword is read back.

// File: rtl/objx_pkg.sv
package objx_pkg;
  localparam int DW = 32;
  localparam int LEN_W = 18;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_WMB  = 2'd1;
  localparam logic [1:0] SEL_RMB  = 2'd2;

  localparam int CTL_ABORT = 0;
  localparam int CTL_GO    = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_COLLECT} mb_state_e;

  // length field of zero encodes the largest object, 2^LEN_W dwords
  function automatic logic [LEN_W:0] obj_len(input logic [LEN_W-1:0] fld);
    obj_len = (fld == '0) ? (LEN_W+1)'(1) << LEN_W : {1'b0, fld};
  endfunction
endpackage

// File: rtl/objx_reqbuf.sv
module objx_reqbuf
  import objx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    push_dw,
  input  logic [CW-1:0]    rd_idx,
  output logic [CW-1:0]    cnt,
  output logic             full,
  output logic [DW-1:0]    rd_dw,
  output logic [LEN_W-1:0] len_fld
);
  logic [DW-1:0] mem [DEPTH];

  assign full    = (cnt == CW'(DEPTH));
  assign rd_dw   = mem[rd_idx[IW-1:0]];
  assign len_fld = mem[1][LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[IW-1:0]] <= push_dw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (push && !full)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/objx_rspbuf.sv
module objx_rspbuf
  import objx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_dw,
  input  logic          pop,
  output logic          full,
  output logic          last_left,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] fill;
  logic [CW-1:0] rptr;

  assign full      = (fill == CW'(DEPTH));
  assign last_left = ((rptr + CW'(1)) == fill);
  assign head      = mem[rptr[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[fill[IW-1:0]] <= push_dw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      rptr <= '0;
    end else if (clr) begin
      fill <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) fill <= fill + CW'(1);
      if (pop)           rptr <= rptr + CW'(1);
    end
  end
endmodule

// File: rtl/objx_seq.sv
module objx_seq
  import objx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic             ctl_abort,
  input  logic             ctl_go,
  input  logic [CW-1:0]    req_cnt,
  input  logic             req_full,
  input  logic [LEN_W-1:0] len_fld,
  input  logic             req_rdy,
  input  logic             rsp_vld,
  input  logic             rsp_last,
  input  logic             rsp_full,
  input  logic             rsp_last_left,
  output logic             busy,
  output logic             err,
  output logic             ready,
  output logic             req_vld,
  output logic             req_last,
  output logic             rsp_rdy,
  output logic [CW-1:0]    send_idx,
  output logic             req_push,
  output logic             req_clr,
  output logic             rsp_push,
  output logic             rsp_clr,
  output logic             rsp_pop,
  output logic             ev_abort,
  output logic             ev_go_ok,
  output logic             ev_go_bad,
  output logic             ev_wr_drop,
  output logic             ev_ovf,
  output logic             ev_rsp_ovf
);
  mb_state_e       st;
  logic            err_q, rdy_q;
  logic [CW-1:0]   idx_q, len_q;
  logic            ctl_wr, wmb_wr, rmb_wr, go_live, len_ok, idle;
  logic [LEN_W:0]  len;

  assign idle    = (st == ST_IDLE);
  assign ctl_wr  = host_we && (host_sel == SEL_CTRL);
  assign wmb_wr  = host_we && (host_sel == SEL_WMB);
  assign rmb_wr  = host_we && (host_sel == SEL_RMB);
  assign len     = obj_len(len_fld);
  assign len_ok  = (req_cnt >= CW'(2)) && (len >= (LEN_W+1)'(2)) &&
                   (32'(len) <= 32'(req_cnt));

  assign ev_abort   = ctl_wr && ctl_abort;
  assign go_live    = ctl_wr && ctl_go && !ctl_abort && idle && !err_q && !rdy_q;
  assign ev_go_ok   = go_live && len_ok;
  assign ev_go_bad  = go_live && !len_ok;
  assign ev_wr_drop = wmb_wr && !idle;
  assign ev_ovf     = wmb_wr && idle && req_full;
  assign ev_rsp_ovf = (st == ST_COLLECT) && rsp_vld && rsp_full;

  assign req_push = wmb_wr && idle && !req_full;
  assign req_clr  = ev_abort || ev_go_ok;
  assign rsp_clr  = ev_abort || ev_go_ok;
  assign rsp_push = (st == ST_COLLECT) && rsp_vld && !rsp_full;
  assign rsp_pop  = rmb_wr && rdy_q;

  assign busy     = !idle;
  assign err      = err_q;
  assign ready    = rdy_q;
  assign req_vld  = (st == ST_SEND);
  assign req_last = (st == ST_SEND) && (idx_q == len_q - CW'(1));
  assign rsp_rdy  = (st == ST_COLLECT);
  assign send_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      err_q <= 1'b0;
      rdy_q <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else if (ev_abort) begin
      st    <= ST_IDLE;
      err_q <= 1'b0;
      rdy_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (ev_go_bad || ev_wr_drop || ev_ovf || ev_rsp_ovf) err_q <= 1'b1;
      if (rsp_pop && rsp_last_left) rdy_q <= 1'b0;
      case (st)
        ST_IDLE: if (ev_go_ok) begin
          st    <= ST_SEND;
          idx_q <= '0;
          len_q <= CW'(len);
        end
        ST_SEND: if (req_rdy) begin
          if (req_last) st <= ST_COLLECT;
          else          idx_q <= idx_q + CW'(1);
        end
        ST_COLLECT: if (rsp_vld && rsp_last) begin
          st    <= ST_IDLE;
          rdy_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/objx_mailbox.sv
module objx_mailbox
  import objx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        st_busy,
  output logic        st_error,
  output logic        st_ready,
  output logic        req_vld,
  output logic [31:0] req_dw,
  output logic        req_last,
  input  logic        req_rdy,
  input  logic        rsp_vld,
  input  logic [31:0] rsp_dw,
  input  logic        rsp_last,
  output logic        rsp_rdy
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    req_cnt, send_idx;
  logic [LEN_W-1:0] len_fld;
  logic [DW-1:0]    rsp_head;
  logic req_full, rsp_full, rsp_last_left;
  logic req_push, req_clr, rsp_push, rsp_clr, rsp_pop;
  logic ev_abort, ev_go_ok, ev_go_bad, ev_wr_drop, ev_ovf, ev_rsp_ovf;

  objx_reqbuf #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n), .clr(req_clr), .push(req_push),
    .push_dw(host_wdata), .rd_idx(send_idx), .cnt(req_cnt),
    .full(req_full), .rd_dw(req_dw), .len_fld(len_fld)
  );

  objx_rspbuf #(.DEPTH(DEPTH)) u_rsp (
    .clk(clk), .rst_n(rst_n), .clr(rsp_clr), .push(rsp_push),
    .push_dw(rsp_dw), .pop(rsp_pop), .full(rsp_full),
    .last_left(rsp_last_left), .head(rsp_head)
  );

  objx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .ctl_abort(host_wdata[CTL_ABORT]), .ctl_go(host_wdata[CTL_GO]),
    .req_cnt(req_cnt), .req_full(req_full), .len_fld(len_fld),
    .req_rdy(req_rdy), .rsp_vld(rsp_vld), .rsp_last(rsp_last),
    .rsp_full(rsp_full), .rsp_last_left(rsp_last_left),
    .busy(st_busy), .err(st_error), .ready(st_ready),
    .req_vld(req_vld), .req_last(req_last), .rsp_rdy(rsp_rdy),
    .send_idx(send_idx), .req_push(req_push), .req_clr(req_clr),
    .rsp_push(rsp_push), .rsp_clr(rsp_clr), .rsp_pop(rsp_pop),
    .ev_abort(ev_abort), .ev_go_ok(ev_go_ok), .ev_go_bad(ev_go_bad),
    .ev_wr_drop(ev_wr_drop), .ev_ovf(ev_ovf), .ev_rsp_ovf(ev_rsp_ovf)
  );

  assign host_rdata = st_ready ? rsp_head : '0;
endmodule

// File: rtl/objx_mailbox_chk.sv
module objx_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [1:0]  host_sel,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic        st_busy,
  input logic        st_error,
  input logic        st_ready,
  input logic        req_vld,
  input logic [31:0] req_dw,
  input logic        req_last,
  input logic        req_rdy,
  input logic        rsp_rdy,
  input logic        ev_abort,
  input logic        ev_go_ok,
  input logic        ev_go_bad,
  input logic        ev_wr_drop,
  input logic        ev_ovf,
  input logic        ev_rsp_ovf
);
  logic go_wr, ack_wr;
  assign go_wr  = host_we && host_sel == 2'd0 && host_wdata[31] && !host_wdata[0];
  assign ack_wr = host_we && host_sel == 2'd2;

  assert_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_go_ok |=> (st_busy && req_vld));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_rdy && !ev_abort) |=> (req_vld && $stable(req_dw) && $stable(req_last)));
  assert_go_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_go_bad |=> (st_error && !st_busy && !req_vld));
  assert_wr_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_drop |=> st_error);
  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> st_error);
  assert_rsp_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_ovf |=> st_error);
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_busy && st_ready));
  assert_rsp_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdy |-> st_busy);
  assert_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> (host_rdata == 32'd0));
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!st_busy && !st_error && !st_ready && !req_vld && !rsp_rdy));
  assert_go_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && req_vld) |=> st_busy);
  assert_go_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && st_ready) |=> !st_busy);
  assert_ack_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !st_ready && !st_busy) |=> !st_ready);
endmodule

bind objx_mailbox objx_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .st_busy(st_busy),
  .st_error(st_error), .st_ready(st_ready), .req_vld(req_vld),
  .req_dw(req_dw), .req_last(req_last), .req_rdy(req_rdy),
  .rsp_rdy(rsp_rdy), .ev_abort(ev_abort), .ev_go_ok(ev_go_ok),
  .ev_go_bad(ev_go_bad), .ev_wr_drop(ev_wr_drop), .ev_ovf(ev_ovf),
  .ev_rsp_ovf(ev_rsp_ovf)
);

// File: tb/sim_objx_mailbox.sv
`timescale 1ns/1ps
module sim_objx_mailbox;
  localparam int D = 8;
  localparam logic [31:0] GO = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic host_we = 0, req_rdy = 0, rsp_vld = 0, rsp_last = 0;
  logic [1:0]  host_sel = 0;
  logic [31:0] host_wdata = 0, rsp_dw = 0;
  logic [31:0] host_rdata, req_dw;
  logic st_busy, st_error, st_ready, req_vld, req_last, rsp_rdy;

  always #2 clk = ~clk;

  objx_mailbox #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .st_busy(st_busy),
    .st_error(st_error), .st_ready(st_ready), .req_vld(req_vld),
    .req_dw(req_dw), .req_last(req_last), .req_rdy(req_rdy),
    .rsp_vld(rsp_vld), .rsp_dw(rsp_dw), .rsp_last(rsp_last), .rsp_rdy(rsp_rdy)
  );

  int total = 0, bad = 0, cyc = 0, rdy_cnt = 0;
  bit done = 0, rdy_hold = 0, cmp_ok;
  string cur_req = "R1";
  logic [31:0] got[$];

  // behavioural reference state
  logic [31:0] m_req[$], m_send[$], m_rsp[$];
  int  m_st = 0, m_n, m_len;
  bit  m_err = 0, m_rdy = 0, e0, r0;
  int  s0;
  longint act_v, exp_v;

  function automatic int objlen(input logic [31:0] h);
    return (h[17:0] == 0) ? 262144 : int'(h[17:0]);
  endfunction

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req.delete(); m_send.delete(); m_rsp.delete();
      m_st = 0; m_err = 0; m_rdy = 0;
    end else begin
      e0 = m_err; r0 = m_rdy; s0 = m_st;
      if (host_we && host_sel == 0 && host_wdata[0]) begin
        m_req.delete(); m_send.delete(); m_rsp.delete();
        m_st = 0; m_err = 0; m_rdy = 0;
      end else begin
        if (host_we && host_sel == 1) begin
          if (s0 != 0 || m_req.size() == D) m_err = 1;
          else m_req.push_back(host_wdata);
        end
        if (host_we && host_sel == 0 && host_wdata[31] && s0 == 0 && !e0 && !r0) begin
          m_n = m_req.size();
          m_len = (m_n >= 2) ? objlen(m_req[1]) : 0;
          if (m_n >= 2 && m_len >= 2 && m_len <= m_n) begin
            m_send.delete();
            for (int i = 0; i < m_len; i++) m_send.push_back(m_req[i]);
            m_req.delete(); m_rsp.delete();
            m_st = 1;
          end else m_err = 1;
        end
        if (host_we && host_sel == 2 && r0) begin
          void'(m_rsp.pop_front());
          if (m_rsp.size() == 0) m_rdy = 0;
        end
        if (s0 == 1 && req_rdy) begin
          void'(m_send.pop_front());
          if (m_send.size() == 0) m_st = 2;
        end
        if (s0 == 2 && rsp_vld) begin
          if (m_rsp.size() < D) m_rsp.push_back(rsp_dw);
          else m_err = 1;
          if (rsp_last) begin m_st = 0; m_rdy = 1; end
        end
      end
    end
  end

  // per-cycle comparison, responder ready pattern, request capture
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp_ok = (st_busy == (m_st != 0)) && (st_error == m_err) && (st_ready == m_rdy) &&
               (req_vld == (m_st == 1)) && (rsp_rdy == (m_st == 2)) &&
               (host_rdata == ((m_rdy && m_rsp.size() > 0) ? m_rsp[0] : 32'd0));
      if (m_st == 1 && m_send.size() > 0)
        cmp_ok = cmp_ok && (req_dw == m_send[0]) && (req_last == (m_send.size() == 1));
      act_v = {st_busy, st_error, st_ready, req_vld, rsp_rdy, host_rdata};
      exp_v = {m_st != 0, m_err, m_rdy, m_st == 1, m_st == 2,
               (m_rdy && m_rsp.size() > 0) ? m_rsp[0] : 32'd0};
      chk(cmp_ok, cur_req, act_v, exp_v);
    end
    rdy_cnt++;
    req_rdy = !rdy_hold && (rdy_cnt % 3 != 2);
    if (rst_n && req_vld && req_rdy) got.push_back(req_dw);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
      summary();
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    host_we = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); #1;
    host_we = 0;
  endtask

  task automatic wait_collect();
    while (!rsp_rdy) idle(1);
  endtask

  task automatic sendr(input int n, input logic [31:0] base, input bit endobj);
    for (int i = 0; i < n; i++) begin
      while (!rsp_rdy) idle(1);
      rsp_vld = 1; rsp_dw = base + i; rsp_last = endobj && (i == n - 1);
      @(negedge clk); #1;
      rsp_vld = 0; rsp_last = 0;
    end
  endtask

  task automatic status(input bit b, input bit e, input bit r, input string tag);
    chk(st_busy == b && st_error == e && st_ready == r, tag,
        {st_busy, st_error, st_ready}, {b, e, r});
  endtask

  logic [31:0] h = 32'h0042_1AB3;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!st_busy && !st_error && !st_ready && !req_vld && !rsp_rdy && host_rdata == 0,
        "R1", {st_busy, st_error, st_ready, req_vld, rsp_rdy}, 0);

    // R2/R3: normal request of 4 dwords
    cur_req = "R3"; got.delete();
    wr(1, h); wr(1, 32'd4); wr(1, 32'h11); wr(1, 32'h22);
    wr(0, GO);
    status(1, 0, 0, "R3");
    wait_collect();
    chk(got.size() == 4, "R3", got.size(), 4);
    if (got.size() == 4) begin
      chk(got[0] == h && got[1] == 4, "R2", got[1], 4);
      chk(got[2] == 32'h11 && got[3] == 32'h22, "R3", got[3], 32'h22);
    end
    cur_req = "R7";
    chk(rsp_rdy, "R7", rsp_rdy, 1);
    sendr(3, 32'hC000_0000, 1);
    status(0, 0, 1, "R7");
    cur_req = "R8";
    chk(host_rdata == 32'hC000_0000, "R8", host_rdata, 32'hC000_0000);
    idle(2);
    chk(host_rdata == 32'hC000_0000, "R8", host_rdata, 32'hC000_0000);
    wr(2, 0);
    chk(host_rdata == 32'hC000_0001 && st_ready, "R8", host_rdata, 32'hC000_0001);
    wr(2, 32'hFFFF);
    chk(host_rdata == 32'hC000_0002 && st_ready, "R8", host_rdata, 32'hC000_0002);
    wr(2, 0);
    chk(!st_ready && host_rdata == 0, "R8", st_ready, 0);

    // R11 ack with nothing ready
    cur_req = "R11";
    wr(2, 0);
    status(0, 0, 0, "R11");

    // R4 short request, then R10 start while error
    cur_req = "R4";
    wr(1, h); wr(1, 32'd5); wr(1, 32'h33);
    wr(0, GO);
    chk(st_error && !st_busy && !req_vld, "R4", {st_error, st_busy}, 2'b10);
    cur_req = "R10";
    wr(1, 32'h44); wr(1, 32'h55);
    wr(0, GO);
    chk(!st_busy && !req_vld && st_error, "R10", st_busy, 0);
    cur_req = "R9";
    wr(0, 32'h1);
    status(0, 0, 0, "R9");

    // R4 length field zero and length one
    cur_req = "R4";
    wr(1, h); wr(1, 32'd0); wr(1, 32'h66);
    wr(0, GO);
    status(0, 1, 0, "R4");
    wr(0, 32'h1);
    wr(1, h); wr(1, 32'd1);
    wr(0, GO);
    status(0, 1, 0, "R4");
    wr(0, 32'h1);

    // R6 overflow of request buffer
    cur_req = "R6";
    wr(1, h); wr(1, D);
    for (int i = 0; i < D - 2; i++) wr(1, 32'h100 + i);
    chk(!st_error, "R6", st_error, 0);
    wr(1, 32'hDEAD);
    chk(st_error, "R6", st_error, 1);
    wr(0, 32'h1);

    // R3 boundary: full-depth request
    cur_req = "R3"; got.delete();
    wr(1, h); wr(1, D);
    for (int i = 0; i < D - 2; i++) wr(1, 32'h200 + i);
    wr(0, GO);
    wait_collect();
    chk(got.size() == D, "R3", got.size(), D);
    if (got.size() == D) chk(got[D-1] == 32'h200 + D - 3, "R3", got[D-1], 32'h200 + D - 3);
    sendr(1, 32'h77, 1);
    cur_req = "R10";
    wr(0, GO);
    chk(!st_busy && st_ready && host_rdata == 32'h77, "R10", host_rdata, 32'h77);
    wr(2, 0);
    wr(0, 32'h1);

    // R5 write while a request dword is stalled
    cur_req = "R5"; got.delete(); rdy_hold = 1;
    wr(1, h); wr(1, 32'd3); wr(1, 32'h88);
    wr(0, GO);
    idle(2);
    chk(req_vld && req_dw == h, "R3", req_dw, h);
    wr(1, 32'hBAD0);
    chk(st_error && req_vld && req_dw == h, "R5", req_dw, h);
    cur_req = "R10";
    wr(0, GO);
    chk(st_busy && req_vld && req_dw == h, "R10", req_dw, h);
    rdy_hold = 0;
    cur_req = "R5";
    wait_collect();
    chk(got.size() == 3, "R5", got.size(), 3);
    if (got.size() == 3) chk(got[2] == 32'h88, "R5", got[2], 32'h88);
    sendr(1, 32'h99, 1);
    wr(0, 32'h1);

    // R7 response longer than the buffer
    cur_req = "R7";
    wr(1, h); wr(1, 32'd2);
    wr(0, GO);
    wait_collect();
    sendr(D + 2, 32'hB000, 1);
    status(0, 1, 1, "R7");
    for (int i = 0; i < D; i++) begin
      chk(host_rdata == 32'hB000 + i && st_ready, "R7", host_rdata, 32'hB000 + i);
      wr(2, 0);
    end
    chk(!st_ready, "R8", st_ready, 0);
    wr(0, 32'h1);

    // R9 abort during send, during collect, and with start in same write
    cur_req = "R9"; rdy_hold = 1;
    wr(1, h); wr(1, 32'd2);
    wr(0, GO);
    idle(1);
    chk(req_vld, "R9", req_vld, 1);
    wr(0, 32'h1);
    chk(!req_vld && !st_busy, "R9", req_vld, 0);
    rdy_hold = 0;
    wr(1, h); wr(1, 32'd2);
    wr(0, GO);
    wait_collect();
    sendr(1, 32'h5000, 0);
    chk(rsp_rdy, "R7", rsp_rdy, 1);
    wr(0, 32'h1);
    chk(!rsp_rdy && !st_busy && !st_ready, "R9", rsp_rdy, 0);
    wr(1, h); wr(1, 32'd2);
    wr(0, GO | 32'h1);
    status(0, 0, 0, "R9");
    cur_req = "R4";
    wr(0, GO);
    status(0, 1, 0, "R4");
    wr(0, 32'h1);
    idle(3);
    summary();
  end
endmodule